// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block derives the SPI serial clock from a faster reference clock. A 32-bit clock configuration word holds a period count and an active-phase count, each 6 bits wide. While the transfer engine holds its clock request high, an internal phase counter steps once per reference cycle from 0 up to the period count and then wraps. For the first part of each period the serial clock sits at its active level, and for the rest it sits at its inactive level. When the request is low the counter is held at zero and the serial clock rests at a separately programmed idle level.

The engine also receives two one-cycle strobes. The leading strobe marks the start of each period. The trailing strobe marks the cycle where the active phase ends. The engine uses these strobes to launch and capture data bits. A polarity bit swaps the active and inactive levels, so both idle-high and idle-low clocking schemes can be set up. The divider field and the source flag of the configuration word are accepted but have no effect on timing.

Top module: `spiclk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sck`, `lead_stb` and `trail_stb` are all 0.
- R2: Each rising edge that samples `clk_req` low sets `sck` to the value of `idle_high` and clears both strobes. The next period always starts at phase 0.
- R3: The period count P is taken from `clock_cfg[5:0]`. After the k-th consecutive rising edge that samples `clk_req` high (k = 0, 1, ...), the output phase is k mod (P+1). `lead_stb` is 1 exactly when that phase is 0.
- R4: The active-phase count H is taken from `clock_cfg[11:6]`. The serial clock is at its active level for phases 0..H and at its inactive level for later phases. When H >= P, it is active for the whole period.
- R5: `trail_stb` is 1 exactly when the output phase equals H+1. It therefore never fires when H >= P.
- R6: When `clk_noinv` = 0 the active level is 1 and the inactive level is 0. When `clk_noinv` = 1 the active level is 0 and the inactive level is 1.
- R7: The divider field `clock_cfg[17:12]` and the source flag `clock_cfg[31]` have no effect on `sck` or on either strobe.
- R8: With P = 0, `lead_stb` is 1 on every enabled cycle, `sck` holds its active level, and `trail_stb` stays 0.
- R9: With the usual setting of P = n and H = (n+1)/2 - 1 (integer division), the active phase lasts (n+1)/2 of the n+1 cycles in each period. For n = 63 this is 32 active cycles out of 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clock_cfg | input | 32 | Clock configuration word: period [5:0], active count [11:6], divider [17:12], source [31] |
| clk_noinv | input | 1 | Polarity select: 1 makes the active level 0 |
| idle_high | input | 1 | Level of `sck` while clocking is not requested |
| clk_req | input | 1 | Clock request from the transfer engine |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe at phase 0 of each period |
| trail_stb | output | 1 | One-cycle strobe at the end of the active phase |

## Verification
A phase counter that wraps at the wrong count moves the next `lead_stb` earlier or later. The error becomes visible within one period, at most 64 reference cycles. A wrong comparison against the active count changes the `sck` level or misplaces `trail_stb` within that same period. A counter that is not cleared when the request drops shows up at the very next start: the first enabled cycle lacks its leading strobe. Every output is a register fed from the current phase, so each fault reaches the pins exactly one reference cycle after the phase that caused it.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
  localparam int CNT_W = 6;

  typedef logic [CNT_W-1:0] cnt_t;

  // Next phase value: wrap to zero at or beyond the period count.
  function automatic cnt_t phase_next(input cnt_t cur, input cnt_t per);
    if (cur >= per) return '0;
    return cur + 1'b1;
  endfunction

  // True while the phase is within the active part of the period.
  function automatic logic phase_is_active(input cnt_t cur, input cnt_t hi);
    return (cur <= hi);
  endfunction

  // True on the first phase past the active part.
  function automatic logic phase_is_trail(input cnt_t cur, input cnt_t hi);
    return ({1'b0, cur} == ({1'b0, hi} + 1'b1));
  endfunction
endpackage

// File: rtl/spiclk_phase_counter.sv
module spiclk_phase_counter
  import spiclk_pkg::*;
(
  input  logic clk_ref,
  input  logic rst_n,
  input  logic run,
  input  cnt_t per_cnt,
  output cnt_t phase
);
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (!run) phase <= '0;
    else          phase <= phase_next(phase, per_cnt);
  end
endmodule

// File: rtl/spiclk_edge_decode.sv
module spiclk_edge_decode
  import spiclk_pkg::*;
(
  input  cnt_t phase,
  input  cnt_t hi_cnt,
  output logic in_active,
  output logic at_lead,
  output logic at_trail
);
  always_comb begin
    in_active = phase_is_active(phase, hi_cnt);
    at_lead   = (phase == '0);
    at_trail  = phase_is_trail(phase, hi_cnt);
  end
endmodule

// File: rtl/spiclk_out_stage.sv
module spiclk_out_stage (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic run,
  input  logic in_active,
  input  logic at_lead,
  input  logic at_trail,
  input  logic noinv,
  input  logic idle_lvl,
  output logic sck_q,
  output logic lead_q,
  output logic trail_q
);
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run) begin
      sck_q   <= idle_lvl;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      sck_q   <= in_active ^ noinv;
      lead_q  <= at_lead;
      trail_q <= at_trail;
    end
  end
endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
  import spiclk_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int PER_LSB  = 0,
  parameter int HI_LSB   = 6,
  parameter int DIV_LSB  = 12,
  parameter int SRC_BIT  = 31
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] clock_cfg,
  input  logic             clk_noinv,
  input  logic             idle_high,
  input  logic             clk_req,
  output logic             sck,
  output logic             lead_stb,
  output logic             trail_stb
);
  localparam int PER_MSB = PER_LSB + CNT_W - 1;
  localparam int HI_MSB  = HI_LSB + CNT_W - 1;
  localparam int DIV_MSB = DIV_LSB + CNT_W - 1;

  cnt_t per_cnt, hi_cnt, div_fld;
  logic src_sel;
  cnt_t phase;
  logic in_active, at_lead, at_trail;

  assign per_cnt = clock_cfg[PER_MSB:PER_LSB];
  assign hi_cnt  = clock_cfg[HI_MSB:HI_LSB];
  // Divider field and source flag are decoded but do not steer timing.
  assign div_fld = clock_cfg[DIV_MSB:DIV_LSB];
  assign src_sel = clock_cfg[SRC_BIT];

  logic unused_cfg;
  assign unused_cfg = ^{div_fld, src_sel};

  spiclk_phase_counter u_cnt (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .run     (clk_req),
    .per_cnt (per_cnt),
    .phase   (phase)
  );

  spiclk_edge_decode u_dec (
    .phase     (phase),
    .hi_cnt    (hi_cnt),
    .in_active (in_active),
    .at_lead   (at_lead),
    .at_trail  (at_trail)
  );

  spiclk_out_stage u_out (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .run       (clk_req),
    .in_active (in_active),
    .at_lead   (at_lead),
    .at_trail  (at_trail),
    .noinv     (clk_noinv),
    .idle_lvl  (idle_high),
    .sck_q     (sck),
    .lead_q    (lead_stb),
    .trail_q   (trail_stb)
  );
endmodule

// File: rtl/spiclk_gen_chk.sv
module spiclk_gen_chk
  import spiclk_pkg::*;
(
  input logic clk_ref,
  input logic rst_n,
  input logic clk_req,
  input logic clk_noinv,
  input logic idle_high,
  input cnt_t per_cnt,
  input cnt_t hi_cnt,
  input cnt_t phase,
  input logic sck,
  input logic lead_stb,
  input logic trail_stb
);
  logic armed;
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: outputs low while reset is applied
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!sck && !lead_stb && !trail_stb);
    end
  end

  p_idle_level_r2: assert property (@(posedge clk_ref) disable iff (!rst_n || !armed)
    !$past(clk_req) |-> (sck == $past(idle_high)) && !lead_stb && !trail_stb);

  p_held_zero_r2: assert property (@(posedge clk_ref) disable iff (!rst_n || !armed)
    !$past(clk_req) |-> phase == '0);

  p_wrap_r3: assert property (@(posedge clk_ref) disable iff (!rst_n || !armed)
    ($past(clk_req) && ($past(phase) >= $past(per_cnt))) |-> phase == '0);

  p_lead_at_zero_r3: assert property (@(posedge clk_ref) disable iff (!rst_n || !armed)
    lead_stb |-> ($past(clk_req) && $past(phase) == '0));

  p_trail_at_end_r5: assert property (@(posedge clk_ref) disable iff (!rst_n || !armed)
    trail_stb |-> ({1'b0, $past(phase)} == {1'b0, $past(hi_cnt)} + 7'd1));

  p_lead_active_r6: assert property (@(posedge clk_ref) disable iff (!rst_n || !armed)
    lead_stb |-> sck == !$past(clk_noinv));

  p_strobes_apart_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $countones({lead_stb, trail_stb}) <= 1);
endmodule

bind spiclk_gen spiclk_gen_chk u_chk (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .clk_req   (clk_req),
  .clk_noinv (clk_noinv),
  .idle_high (idle_high),
  .per_cnt   (per_cnt),
  .hi_cnt    (hi_cnt),
  .phase     (phase),
  .sck       (sck),
  .lead_stb  (lead_stb),
  .trail_stb (trail_stb)
);

// File: tb/spiclk_gen_tb.sv
`timescale 1ns/1ps
module spiclk_gen_tb;
  logic        clk_ref = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] clock_cfg = '0;
  logic        clk_noinv = 1'b0;
  logic        idle_high = 1'b0;
  logic        clk_req = 1'b0;
  logic        sck, lead_stb, trail_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_ref = ~clk_ref;

  spiclk_gen u_dut (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .clock_cfg (clock_cfg),
    .clk_noinv (clk_noinv),
    .idle_high (idle_high),
    .clk_req   (clk_req),
    .sck       (sck),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs one configuration and compares against the arithmetic model.
  task automatic run_case(input int p, input int h, input bit inv, input bit idl,
                          input int junk_div, input bit junk_src, input string req);
    @(negedge clk_ref);
    clock_cfg = {junk_src, 13'd0, junk_div[5:0], h[5:0], p[5:0]};
    clk_noinv = inv;
    idle_high = idl;
    clk_req   = 1'b0;
    @(posedge clk_ref); @(negedge clk_ref);
    check("R2", "idle sck", sck, idl);
    check("R2", "idle lead", lead_stb, 0);
    clk_req = 1'b1;
    for (int k = 0; k < 2 * (p + 1) + 2; k++) begin
      int ph;
      bit act;
      @(posedge clk_ref); @(negedge clk_ref);
      ph  = k % (p + 1);
      act = (ph <= h);
      check(req, "sck", sck, act ^ inv);
      check(req, "lead", lead_stb, ph == 0);
      check(req, "trail", trail_stb, ph == h + 1);
    end
    clk_req = 1'b0;
    @(posedge clk_ref); @(negedge clk_ref);
    check("R2", "sck after drop", sck, idl);
    check("R2", "strobes after drop", lead_stb | trail_stb, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int act_cnt;
    // R1: reset state
    #1;
    check("R1", "sck in reset", sck, 0);
    check("R1", "lead in reset", lead_stb, 0);
    check("R1", "trail in reset", trail_stb, 0);
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
    @(posedge clk_ref); @(negedge clk_ref);
    check("R1", "sck after reset", sck, 0);
    check("R1", "strobes after reset", lead_stb | trail_stb, 0);

    // R3 R4 R5 R6: sweep of small period and active counts
    for (int p = 0; p < 8; p++)
      for (int h = 0; h < 8; h++)
        for (int inv = 0; inv < 2; inv++)
          run_case(p, h, inv[0], ((p + h) % 2) == 1, 0, 1'b0,
                   (p == 0) ? "R8" : (h >= p ? "R4" : "R5"));

    // R6: polarity against idle combinations on a fixed shape
    run_case(5, 2, 1'b1, 1'b1, 0, 1'b0, "R6");
    run_case(5, 2, 1'b0, 1'b0, 0, 1'b0, "R6");

    // R7: divider field and source flag carry junk
    run_case(6, 3, 1'b0, 1'b1, 45, 1'b1, "R7");
    run_case(3, 1, 1'b1, 1'b0, 63, 1'b0, "R7");

    // R9: usual setting with n = 63
    run_case(63, 31, 1'b0, 1'b0, 63, 1'b0, "R9");

    // R9: count active cycles over one full period with n = 63
    @(negedge clk_ref);
    clock_cfg = {14'd0, 6'd63, 6'd31, 6'd63};
    clk_noinv = 1'b0;
    clk_req   = 1'b1;
    act_cnt   = 0;
    for (int k = 0; k < 64; k++) begin
      @(posedge clk_ref); @(negedge clk_ref);
      act_cnt += sck;
    end
    check("R9", "active cycles per period", act_cnt, 32);
    clk_req = 1'b0;
    @(posedge clk_ref); @(negedge clk_ref);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule